// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits behind the write port of a NOR-style flash array. It watches asynchronous-style bus writes (address, data, active-low write enable, active-low chip enable), which are sampled in the core clock domain. It recognises the six-write erase command sequences and runs the erase state machine for the whole block.

A sector erase opens an acceptance window. During the window more sectors can be queued with single writes, and each one restarts the window. When the window lapses, an embedded erase runs over the queued set. The erase has three phases in order: program the region to zero, verify it, then erase. A chip erase runs the same embedded erase over every sector and cannot be interrupted. A sector erase can be suspended and resumed.

Sector completion is modelled by a per-sector erase counter. The counters stand in for the physical array and show which sectors each erase touched.

Top module: `erase_sequencer`

## Requirements
- R1: After reset, sector_sel is all zeros and every erase counter is zero. erase_busy, tmr_expired and erase_suspended are low, and erase_phase is 0.
- R2: A write is taken on the clock edge that first sees bus_we_n high after low while bus_ce_n is low. A sector erase needs six such writes in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, then a sector address with data 0x30. Only the low 11 address bits are compared. The sector number is address bits [13:11]. The sixth write sets bit (sector number) of sector_sel, and tmr_expired and erase_busy stay low.
- R3: A write whose address or data breaks the expected sequence sends the decoder back to read mode. Later writes that would only complete the broken sequence change nothing.
- R4: In the window, a write with data 0x30 adds the sector in address bits [13:11] and restarts the window. This also holds for a write that lands in the very cycle the window would have closed.
- R5: When WIN_CYC cycles pass after the last accepted sector write with no further write, the erase starts: erase_busy and tmr_expired go high.
- R6: In the window, any write whose data is neither 0x30 nor 0xB0 clears sector_sel and returns to read mode, so no erase follows.
- R7: The embedded erase reports erase_phase 1 (zero-program), then 2 (verify), then 3 (erase), each for PHASE_CYC cycles. It then returns to read mode: erase_busy low, erase_phase 0, sector_sel cleared, and the counter of each selected sector incremented by one.
- R8: Data 0xB0 during a sector erase suspends it: erase_suspended high, erase_busy low, phase held. While suspended, writes other than data 0x30 are ignored. Data 0x30 resumes the erase, which finishes after exactly the cycles that remained.
- R9: Data 0xB0 during the window suspends with tmr_expired low and the queue kept. A later 0x30 write starts the erase at once.
- R10: While a sector erase runs, every write except data 0xB0 is ignored: sector_sel and erase_busy do not change.
- R11: The chip erase sequence (final write 0x555/0x10) selects all sectors and starts the erase at once. During it every write is ignored, 0xB0 included. On completion every counter is incremented.
- R12: Writes made with bus_ce_n high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Write address |
| bus_data | input | 8 | Write data |
| bus_we_n | input | 1 | Write enable, active low; write taken on its rising edge |
| bus_ce_n | input | 1 | Chip enable, active low |
| sector_sel | output | 2**SBW | Bitmap of queued or erasing sectors |
| erase_busy | output | 1 | Embedded erase running |
| tmr_expired | output | 1 | Acceptance window closed and sector erase under way |
| erase_suspended | output | 1 | Erase or window suspended |
| erase_phase | output | 2 | 0 idle, 1 zero-program, 2 verify, 3 erase |
| erase_count | output | (2**SBW)*CW | Per-sector erase counters, sector k at bits [k*CW +: CW] |

## Verification
A write can arrive in the very cycle the acceptance window counter reaches zero. There the window expiry and the command decode compete for the same edge. The bench times a sector-add write so that its strobe lands on exactly that edge. It judges the outcome by erase_busy and tmr_expired staying low, and by the new sector appearing in sector_sel. A second collision is a suspend landing mid-phase: the bench checks the held phase and counts the exact cycles to completion after resume.

// File: rtl/erase_pkg.sv
package erase_pkg;

    localparam int CMD_AW = 11;

    localparam logic [7:0] CMD_KEY1   = 8'hAA;
    localparam logic [7:0] CMD_KEY2   = 8'h55;
    localparam logic [7:0] CMD_SETUP  = 8'h80;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_SECTOR = 8'h30;
    localparam logic [7:0] CMD_SUSP   = 8'hB0;

    localparam logic [CMD_AW-1:0] ADR_KEYA = 11'h555;
    localparam logic [CMD_AW-1:0] ADR_KEYB = 11'h2AA;

    typedef enum logic [2:0] {
        DS_IDLE, DS_K1, DS_K2, DS_SETUP, DS_K3, DS_K4
    } dec_state_t;

    typedef enum logic [1:0] {
        MD_READ, MD_WINDOW, MD_ERASE, MD_SUSP
    } mode_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0, PH_ZERO = 2'd1, PH_VERIFY = 2'd2, PH_ERASE = 2'd3
    } phase_t;

    typedef struct packed {
        logic [CMD_AW-1:0] adr;
        logic [7:0]        dat;
    } bus_word_t;

    // Write expected next in the unlock chain for a given decoder state
    function automatic bus_word_t expect_word(dec_state_t s);
        case (s)
            DS_K1:    return '{adr: ADR_KEYB, dat: CMD_KEY2};
            DS_K2:    return '{adr: ADR_KEYA, dat: CMD_SETUP};
            DS_SETUP: return '{adr: ADR_KEYA, dat: CMD_KEY1};
            DS_K3:    return '{adr: ADR_KEYB, dat: CMD_KEY2};
            default:  return '{adr: ADR_KEYA, dat: CMD_KEY1};
        endcase
    endfunction

endpackage

// File: rtl/erase_cmd_decode.sv
module erase_cmd_decode
    import erase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr_stb,
    input  logic [CMD_AW-1:0] wr_adr,
    input  logic [7:0]        wr_dat,
    output logic              sec_cmd,
    output logic              chip_cmd
);

    dec_state_t st_q;
    bus_word_t  want;
    logic       step_ok;

    always_comb begin
        want     = expect_word(st_q);
        step_ok  = (wr_adr == want.adr) && (wr_dat == want.dat);
        sec_cmd  = en && wr_stb && (st_q == DS_K4) && (wr_dat == CMD_SECTOR);
        chip_cmd = en && wr_stb && (st_q == DS_K4) && (wr_dat == CMD_CHIP)
                   && (wr_adr == ADR_KEYA);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st_q <= DS_IDLE;
        end else if (wr_stb) begin
            if (st_q == DS_K4 || !step_ok) st_q <= DS_IDLE;
            else                           st_q <= dec_state_t'(st_q + 3'd1);
        end
    end

    // R3
    break_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (en && wr_stb && st_q != DS_K4 && !step_ok) |=> (st_q == DS_IDLE));

endmodule

// File: rtl/erase_window.sv
module erase_window #(
    parameter int NSEC    = 8,
    parameter int SBW     = 3,
    parameter int WIN_CYC = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            hold,
    input  logic            load,
    input  logic            load_all,
    input  logic            clear,
    input  logic [SBW-1:0]  idx,
    output logic [NSEC-1:0] sel,
    output logic            expire
);

    localparam int TW = $clog2(WIN_CYC + 1);

    logic [TW-1:0]   cnt_q;
    logic [NSEC-1:0] sel_q;

    assign sel    = sel_q;
    assign expire = run && !hold && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            cnt_q <= '0;
        end else begin
            if (clear)         sel_q      <= '0;
            else if (load_all) sel_q      <= '1;
            else if (load)     sel_q[idx] <= 1'b1;

            if (load)                      cnt_q <= TW'(WIN_CYC - 1);
            else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        end
    end

    // R4
    window_restart_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> !expire);

endmodule

// File: rtl/erase_engine.sv
module erase_engine
    import erase_pkg::*;
#(
    parameter int NSEC      = 8,
    parameter int PHASE_CYC = 16,
    parameter int CW        = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               run,
    input  logic [NSEC-1:0]    sel,
    output phase_t             phase,
    output logic               done,
    output logic [NSEC*CW-1:0] counts
);

    localparam int PW = $clog2(PHASE_CYC + 1);

    phase_t        ph_q;
    logic [PW-1:0] pcnt_q;

    assign phase = ph_q;
    assign done  = run && !start && (ph_q == PH_ERASE) && (pcnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            pcnt_q <= '0;
        end else if (start) begin
            ph_q   <= PH_ZERO;
            pcnt_q <= PW'(PHASE_CYC - 1);
        end else if (run && ph_q != PH_IDLE) begin
            if (pcnt_q == '0) begin
                ph_q   <= (ph_q == PH_ERASE) ? PH_IDLE : phase_t'(ph_q + 2'd1);
                pcnt_q <= PW'(PHASE_CYC - 1);
            end else begin
                pcnt_q <= pcnt_q - 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NSEC; i++) begin : g_cnt
        logic [CW-1:0] c_q;
        always_ff @(posedge clk) begin
            if (rst)               c_q <= '0;
            else if (done && sel[i]) c_q <= c_q + 1'b1;
        end
        assign counts[i*CW +: CW] = c_q;
    end

    // R7
    phase_order_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q != $past(ph_q) && $past(ph_q) != PH_IDLE && ph_q != PH_IDLE)
        |-> (ph_q == phase_t'($past(ph_q) + 2'd1)));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> ($stable(ph_q) && $stable(pcnt_q)));

endmodule

// File: rtl/erase_sequencer.sv
module erase_sequencer
    import erase_pkg::*;
#(
    parameter int AW        = 14,
    parameter int SBW       = 3,
    parameter int WIN_CYC   = 64,
    parameter int PHASE_CYC = 16,
    parameter int CW        = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [AW-1:0]             bus_addr,
    input  logic [7:0]                bus_data,
    input  logic                      bus_we_n,
    input  logic                      bus_ce_n,
    output logic [(1<<SBW)-1:0]       sector_sel,
    output logic                      erase_busy,
    output logic                      tmr_expired,
    output logic                      erase_suspended,
    output logic [1:0]                erase_phase,
    output logic [(1<<SBW)*CW-1:0]    erase_count
);

    localparam int NSEC = 1 << SBW;

    mode_t  mode_q;
    logic   chip_q, susp_erase_q, we_q;
    logic   wr_stb, is_sec, is_susp;
    logic   sec_cmd, chip_cmd;
    logic   win_load, win_clear, win_expire;
    logic   eng_start, eng_done;
    phase_t eng_phase;

    always_comb begin
        wr_stb    = !we_q && bus_we_n && !bus_ce_n;
        is_sec    = (bus_data == CMD_SECTOR);
        is_susp   = (bus_data == CMD_SUSP);
        win_load  = sec_cmd || (mode_q == MD_WINDOW && wr_stb && is_sec);
        win_clear = eng_done || (mode_q == MD_WINDOW && wr_stb && !is_sec && !is_susp);
        eng_start = win_expire || chip_cmd
                    || (mode_q == MD_SUSP && !susp_erase_q && wr_stb && is_sec);
    end

    erase_cmd_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .en       (mode_q == MD_READ),
        .wr_stb   (wr_stb),
        .wr_adr   (bus_addr[CMD_AW-1:0]),
        .wr_dat   (bus_data),
        .sec_cmd  (sec_cmd),
        .chip_cmd (chip_cmd)
    );

    erase_window #(.NSEC(NSEC), .SBW(SBW), .WIN_CYC(WIN_CYC)) u_win (
        .clk      (clk),
        .rst      (rst),
        .run      (mode_q == MD_WINDOW),
        .hold     (wr_stb),
        .load     (win_load),
        .load_all (chip_cmd),
        .clear    (win_clear),
        .idx      (bus_addr[AW-1 -: SBW]),
        .sel      (sector_sel),
        .expire   (win_expire)
    );

    erase_engine #(.NSEC(NSEC), .PHASE_CYC(PHASE_CYC), .CW(CW)) u_eng (
        .clk    (clk),
        .rst    (rst),
        .start  (eng_start),
        .run    (mode_q == MD_ERASE),
        .sel    (sector_sel),
        .phase  (eng_phase),
        .done   (eng_done),
        .counts (erase_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q       <= MD_READ;
            chip_q       <= 1'b0;
            susp_erase_q <= 1'b0;
            we_q         <= 1'b1;
        end else begin
            we_q <= bus_we_n;
            case (mode_q)
                MD_READ: begin
                    if (chip_cmd) begin
                        mode_q <= MD_ERASE;
                        chip_q <= 1'b1;
                    end else if (sec_cmd) begin
                        mode_q <= MD_WINDOW;
                    end
                end
                MD_WINDOW: begin
                    if (wr_stb) begin
                        if (is_susp) begin
                            mode_q       <= MD_SUSP;
                            susp_erase_q <= 1'b0;
                        end else if (!is_sec) begin
                            mode_q <= MD_READ;
                        end
                    end else if (win_expire) begin
                        mode_q <= MD_ERASE;
                    end
                end
                MD_ERASE: begin
                    if (eng_done) begin
                        mode_q <= MD_READ;
                        chip_q <= 1'b0;
                    end else if (wr_stb && is_susp && !chip_q) begin
                        mode_q       <= MD_SUSP;
                        susp_erase_q <= 1'b1;
                    end
                end
                default: begin
                    if (wr_stb && is_sec) mode_q <= MD_ERASE;
                end
            endcase
        end
    end

    assign erase_busy      = (mode_q == MD_ERASE);
    assign erase_suspended = (mode_q == MD_SUSP);
    assign tmr_expired     = (mode_q == MD_ERASE) || (mode_q == MD_SUSP && susp_erase_q);
    assign erase_phase     = eng_phase;

    // R6
    window_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_WINDOW && wr_stb && !is_sec && !is_susp)
        |=> (mode_q == MD_READ && sector_sel == '0));

    // R10
    erase_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_ERASE && wr_stb && !is_susp && !eng_done)
        |=> (mode_q == MD_ERASE && $stable(sector_sel)));

    // R11
    chip_no_susp_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_ERASE && chip_q) |=> (mode_q != MD_SUSP));

endmodule

// File: tb/erase_sequencer_tb.sv
module erase_sequencer_tb;

    localparam int AW = 14, SBW = 3, WIN = 64, PH = 16, CW = 8;
    localparam int NSEC = 1 << SBW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [AW-1:0]     bus_addr = '0;
    logic [7:0]        bus_data = '0;
    logic              bus_we_n = 1'b1;
    logic              bus_ce_n = 1'b1;
    logic [NSEC-1:0]   sector_sel;
    logic              erase_busy, tmr_expired, erase_suspended;
    logic [1:0]        erase_phase;
    logic [NSEC*CW-1:0] erase_count;

    int n_chk = 0, n_bad = 0;
    int exp_cnt [NSEC];

    always #2 clk = ~clk;

    erase_sequencer #(.AW(AW), .SBW(SBW), .WIN_CYC(WIN), .PHASE_CYC(PH), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_we_n(bus_we_n), .bus_ce_n(bus_ce_n), .sector_sel(sector_sel),
        .erase_busy(erase_busy), .tmr_expired(tmr_expired),
        .erase_suspended(erase_suspended), .erase_phase(erase_phase),
        .erase_count(erase_count)
    );

    typedef struct packed {
        logic [AW-1:0] a;
        logic [7:0]    d;
        logic [7:0]    sel;
    } vec_t;

    localparam vec_t VEC [22] = '{
        '{14'h0555, 8'hAA, 8'h00},  // R2 first unlock
        '{14'h02AA, 8'h55, 8'h00},  // R2
        '{14'h0555, 8'h80, 8'h00},  // R2 set-up
        '{14'h0555, 8'hAA, 8'h00},  // R2
        '{14'h02AA, 8'h55, 8'h00},  // R2
        '{14'h1000, 8'h30, 8'h04},  // R2 sector 2 queued
        '{14'h2800, 8'h30, 8'h24},  // R4 sector 5 added
        '{14'h0000, 8'h30, 8'h25},  // R4 sector 0 added
        '{14'h0555, 8'hF0, 8'h00},  // R6 abort
        '{14'h0555, 8'hAA, 8'h00},  // R3
        '{14'h02AA, 8'h54, 8'h00},  // R3 wrong data
        '{14'h02AA, 8'h55, 8'h00},  // R3
        '{14'h0555, 8'h80, 8'h00},  // R3
        '{14'h0555, 8'hAA, 8'h00},  // R3
        '{14'h02AA, 8'h55, 8'h00},  // R3
        '{14'h1000, 8'h30, 8'h00},  // R3 broken chain, nothing queued
        '{14'h0555, 8'hAA, 8'h00},  // R3
        '{14'h02AB, 8'h55, 8'h00},  // R3 wrong address
        '{14'h0555, 8'h80, 8'h00},  // R3
        '{14'h0555, 8'hAA, 8'h00},  // R3
        '{14'h02AA, 8'h55, 8'h00},  // R3
        '{14'h2000, 8'h30, 8'h00}   // R3
    };

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [7:0] d, logic ce = 1'b0);
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_ce_n = ce; bus_we_n = 1'b0;
        @(negedge clk);
        bus_we_n = 1'b1;
        @(negedge clk);
        bus_ce_n = 1'b1;
    endtask

    task automatic seq(logic [AW-1:0] a, logic [7:0] d, logic ce = 1'b0);
        wr(14'h0555, 8'hAA, ce); wr(14'h02AA, 8'h55, ce); wr(14'h0555, 8'h80, ce);
        wr(14'h0555, 8'hAA, ce); wr(14'h02AA, 8'h55, ce); wr(a, d, ce);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && erase_busy; i++) @(negedge clk);
    endtask

    task automatic chk_counts(string tag);
        for (int k = 0; k < NSEC; k++)
            chk(tag, 64'(erase_count[k*CW +: CW]), 64'(exp_cnt[k]));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int k = 0; k < NSEC; k++) exp_cnt[k] = 0;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);

        // R1 reset state
        chk("R1 sel", 64'(sector_sel), 0);
        chk("R1 flags", {61'd0, erase_busy, tmr_expired, erase_suspended}, 0);
        chk("R1 phase", 64'(erase_phase), 0);
        chk_counts("R1 counts");

        // R2 R3 R4 R6 vector walk
        foreach (VEC[i]) begin
            wr(VEC[i].a, VEC[i].d);
            chk($sformatf("R2/R3/R4/R6 vec%0d sel", i), 64'(sector_sel), 64'(VEC[i].sel));
            chk($sformatf("R2 vec%0d busy/tmr", i), {62'd0, erase_busy, tmr_expired}, 0);
        end
        wait_cyc(WIN + 10);
        chk("R6 no erase after abort", 64'(erase_busy), 0);

        // R4 restart, R5 expiry, R7 phases
        seq(14'h0800, 8'h30);
        wait_cyc(40);
        wr(14'h3000, 8'h30);
        wait_cyc(40);
        chk("R4 window restarted busy", {62'd0, erase_busy, tmr_expired}, 0);
        chk("R4 sel", 64'(sector_sel), 64'h42);
        wait_cyc(30);
        chk("R5 started", {62'd0, erase_busy, tmr_expired}, 3);
        chk("R7 phase zero-program", 64'(erase_phase), 1);
        wait_cyc(16);
        chk("R7 phase verify", 64'(erase_phase), 2);
        wait_cyc(16);
        chk("R7 phase erase", 64'(erase_phase), 3);
        wait_cyc(9);
        chk("R7 last erase cycle busy", 64'(erase_busy), 1);
        wait_cyc(2);
        chk("R7 done busy/phase", {61'd0, erase_busy, erase_phase}, 0);
        chk("R7 sel cleared", 64'(sector_sel), 0);
        exp_cnt[1]++; exp_cnt[6]++;
        chk_counts("R7 counts");

        // R4 write landing on the expiry cycle, R9 window suspend, R8 erase suspend
        seq(14'h1800, 8'h30);
        wait_cyc(WIN - 3);
        wr(14'h2000, 8'h30);
        chk("R4 collision not started", {62'd0, erase_busy, tmr_expired}, 0);
        chk("R4 collision sel", 64'(sector_sel), 64'h18);
        wr(14'h0000, 8'hB0);
        chk("R9 window suspend", {61'd0, erase_busy, tmr_expired, erase_suspended}, 1);
        wait_cyc(100);
        chk("R9 held", {61'd0, erase_busy, tmr_expired, erase_suspended}, 1);
        chk("R9 queue kept", 64'(sector_sel), 64'h18);
        wr(14'h0000, 8'h30);
        chk("R9 resume starts erase", {61'd0, erase_busy, tmr_expired, erase_suspended}, 6);
        wait_cyc(20);
        wr(14'h0000, 8'hB0);
        chk("R8 suspended flags", {61'd0, erase_busy, tmr_expired, erase_suspended}, 3);
        chk("R8 phase held", 64'(erase_phase), 2);
        wr(14'h0555, 8'hAA);
        wait_cyc(200);
        chk("R8 ignored while suspended", {61'd0, erase_busy, tmr_expired, erase_suspended}, 3);
        chk("R8 phase still held", 64'(erase_phase), 2);
        chk("R8 sel kept", 64'(sector_sel), 64'h18);
        wr(14'h0000, 8'h30);
        wait_cyc(24);
        chk("R8 remaining cycles busy", 64'(erase_busy), 1);
        wait_cyc(1);
        chk("R8 done exactly", 64'(erase_busy), 0);
        exp_cnt[3]++; exp_cnt[4]++;
        chk_counts("R8 counts");

        // R10 writes ignored during sector erase
        seq(14'h3800, 8'h30);
        wait_cyc(WIN + 6);
        wr(14'h0000, 8'h30);
        wr(14'h0555, 8'hF0);
        chk("R10 sel unchanged", 64'(sector_sel), 64'h80);
        chk("R10 still erasing", {62'd0, erase_busy, erase_suspended}, 2);
        wait_idle();
        exp_cnt[7]++;
        chk_counts("R10 counts");

        // R11 chip erase
        seq(14'h0555, 8'h10);
        chk("R11 all selected", 64'(sector_sel), 64'hFF);
        chk("R11 busy", {62'd0, erase_busy, tmr_expired}, 3);
        wr(14'h0000, 8'hB0);
        chk("R11 suspend ignored", {62'd0, erase_busy, erase_suspended}, 2);
        wait_idle();
        for (int k = 0; k < NSEC; k++) exp_cnt[k]++;
        chk("R11 idle", 64'(erase_busy), 0);
        chk_counts("R11 counts");

        // R12 chip enable high
        seq(14'h1000, 8'h30, 1'b1);
        chk("R12 ce high sel", 64'(sector_sel), 0);
        wait_cyc(WIN + 10);
        chk("R12 ce high busy", 64'(erase_busy), 0);
        chk_counts("R12 counts");

        finish_run();
    end

endmodule